// File: doc/BRIEF.md
# Frame-Slot GPIO Control/Status Unit

This block sits on the codec side of a serial frame link and owns a bank of general-purpose pins. The pins are not reached through the command/status register path. A dedicated data slot carries them. Once per frame the link logic presents the received slot word together with a one-cycle `frame_valid` strobe. On that strobe the unit does four things:
- It drives every pin configured as an output from its bit of the slot word.
- It samples every pin configured as an input.
- It builds the status slot word that the link sends back.
- It folds any input level change into a sticky interrupt flag.

A small synchronous host port holds two registers. The first is a per-pin direction register. The second is a power register with a read/write power-down bit and a read-only ready bit. All pins come out of reset floating, and stay floating until the controller has powered the bank up and switched a pin to output. Because status is built from what the pins carried before the current frame, a value written in a frame shows up in the status no earlier than the next frame.

Top module: `gpio_slot_unit`

## Requirements
- R1: After synchronous reset, `pin_oe`, `pin_out`, `in_slot` and `irq` are all zero. The direction register (address 0) reads 0000h. The power register (address 1) reads 0100h.
- R2: `pin_oe`, `pin_out`, `in_slot` and `irq` change only on a clock edge where `frame_valid` is high. The edge after a strobe leaves them unchanged if the strobe has dropped.
- R3: On a strobe while powered up, each pin n with direction bit 1 gets `pin_oe`=1 and `pin_out` = `out_slot[n+4]`. Each pin with direction bit 0 gets `pin_oe`=0 and `pin_out`=0, whatever its slot bit holds.
- R4: On a strobe while powered up, `in_slot[n+4]` of an input-configured pin carries the level on `pin_in[n]`. That level must have been held for at least two clocks before the strobe.
- R5: On a strobe while powered up, `in_slot[n+4]` of an output-configured pin carries `pin_out[n]` as it stood before that strobe. A value written in a frame is therefore returned one frame later.
- R6: On a strobe while the power-down bit (bit 8 of the power register) is 1, all pins are tri-stated with `pin_out`=0, and `in_slot` is all zero.
- R7: Power register layout: bit 8 is read/write, and 1 means powered down. Bit 0 is read-only ready. On each strobe, bit 0 takes the inverse of bit 8. All other bits read 0. Direction register bit n at address 0 is read/write, and 1 means output. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R8: On a strobe, if powered up and ready, `irq` and `in_slot[0]` are set when any input-configured pin's sampled level differs from its level at the previous strobe. Level changes on output-configured pins never set it.
- R9: The interrupt flag is sticky. It stays set across strobes whose `out_slot[0]` is 1, and is cleared by a strobe whose `out_slot[0]` is 0, unless a new change arrives at that same strobe.
- R10: `in_slot[3:1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe: `out_slot` holds this frame's word |
| out_slot | input | 20 | Received slot word: pin n at bit n+4, bit 0 is the interrupt keep/clear bit |
| in_slot | output | 20 | Status slot word: pin n at bit n+4, bit 0 is the interrupt flag |
| reg_we | input | 1 | Host register write enable |
| reg_addr | input | 1 | Host register address: 0 is direction, 1 is power |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, registered |
| pin_in | input | 16 | Pin levels seen at the pads |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables; 1 means driven |
| irq | output | 1 | Sticky input-change interrupt |

## Verification
A corrupted direction register shows up at the next strobe. A pin is then enabled or floated wrongly, and that pin's status bit is taken from the wrong source. A lost power-down bit shows up at the next strobe as a non-zero status word. A stale ready bit shows up in a power-register read one clock after the address is presented. A wrong previous-sample register shows up as a spurious or missing interrupt at the strobe that compares against it, and the same value appears on `irq` and `in_slot[0]`.

// File: rtl/gpio_slot_pkg.sv
package gpio_slot_pkg;
  localparam int unsigned GPIO_N   = 16;
  localparam int unsigned SLOT_W   = 20;
  localparam int unsigned PIN_LSB  = 4;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned PD_BIT   = 8;
  localparam int unsigned RDY_BIT  = 0;
  localparam logic        ADDR_DIR = 1'b0;
  localparam logic        ADDR_PWR = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_slot_pkg::*;
#(
  parameter int unsigned N = GPIO_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_valid,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [N-1:0]     dir,
  output logic             pwr_down,
  output logic             ready
);
  logic [REG_W-1:0] pwr_view;
  logic [REG_W-1:0] dir_view;

  always_comb begin
    pwr_view          = '0;
    pwr_view[PD_BIT]  = pwr_down;
    pwr_view[RDY_BIT] = ready;
    dir_view          = '0;
    dir_view[N-1:0]   = dir;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir       <= '0;
      pwr_down  <= 1'b1;
      ready     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_DIR) dir      <= reg_wdata[N-1:0];
      if (reg_we && reg_addr == ADDR_PWR) pwr_down <= reg_wdata[PD_BIT];
      if (frame_valid)                    ready    <= ~pwr_down;
      reg_rdata <= (reg_addr == ADDR_PWR) ? pwr_view : dir_view;
    end
  end
endmodule

// File: rtl/gpio_frame_core.sv
module gpio_frame_core
  import gpio_slot_pkg::*;
#(
  parameter int unsigned N   = GPIO_N,
  parameter int unsigned SW  = SLOT_W,
  parameter int unsigned LSB = PIN_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_valid,
  input  logic [SW-1:0] out_slot,
  input  logic [N-1:0]  pin_sync,
  input  logic [N-1:0]  dir,
  input  logic          pwr_down,
  input  logic          ready,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [SW-1:0] in_slot,
  output logic          irq
);
  logic [N-1:0]  prev_smp;
  logic [N-1:0]  rx_pins;
  logic [N-1:0]  status_pins;
  logic          change;
  logic          irq_nxt;
  logic [SW-1:0] slot_nxt;

  always_comb begin
    rx_pins     = out_slot[LSB +: N];
    status_pins = (pin_sync & ~dir) | (pin_out & dir);
    change      = (|((pin_sync ^ prev_smp) & ~dir)) & ready & ~pwr_down;
    irq_nxt     = change | (irq & out_slot[0]);
    slot_nxt    = '0;
    slot_nxt[LSB +: N] = status_pins;
    slot_nxt[0] = irq_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_smp <= '0;
      pin_out  <= '0;
      pin_oe   <= '0;
      in_slot  <= '0;
      irq      <= 1'b0;
    end else if (frame_valid) begin
      prev_smp <= pin_sync;
      irq      <= irq_nxt;
      if (pwr_down) begin
        pin_out <= '0;
        pin_oe  <= '0;
        in_slot <= '0;
      end else begin
        pin_out <= rx_pins & dir;
        pin_oe  <= dir;
        in_slot <= slot_nxt;
      end
    end
  end
endmodule

// File: rtl/gpio_slot_unit.sv
module gpio_slot_unit
  import gpio_slot_pkg::*;
#(
  parameter int unsigned N   = GPIO_N,
  parameter int unsigned SW  = SLOT_W,
  parameter int unsigned LSB = PIN_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_valid,
  input  logic [SW-1:0]    out_slot,
  output logic [SW-1:0]    in_slot,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N-1:0]     pin_in,
  output logic [N-1:0]     pin_out,
  output logic [N-1:0]     pin_oe,
  output logic             irq
);
  logic [N-1:0] pin_sync;
  logic [N-1:0] dir;
  logic         pwr_down;
  logic         ready;

  gpio_sync #(.W(N)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_ctrl_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .frame_valid(frame_valid),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dir(dir), .pwr_down(pwr_down), .ready(ready)
  );

  gpio_frame_core #(.N(N), .SW(SW), .LSB(LSB)) u_core (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .out_slot(out_slot),
    .pin_sync(pin_sync), .dir(dir), .pwr_down(pwr_down), .ready(ready),
    .pin_out(pin_out), .pin_oe(pin_oe), .in_slot(in_slot), .irq(irq)
  );
endmodule

// File: rtl/gpio_slot_chk.sv
module gpio_slot_chk #(
  parameter int unsigned N   = 16,
  parameter int unsigned SW  = 20,
  parameter int unsigned LSB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_valid,
  input logic          pwr_down,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic [SW-1:0] in_slot,
  input logic          irq
);
  a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> ($stable(pin_oe) && $stable(pin_out) && $stable(in_slot) && $stable(irq)));

  a_r3_no_value_on_floating_pin: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  a_r5_status_lags_drive: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !pwr_down) |=> (((in_slot[LSB +: N] ^ $past(pin_out)) & pin_oe) == '0));

  a_r6_powered_down_quiet: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && pwr_down) |=> (in_slot == '0 && pin_oe == '0));

  a_r9_flag_matches_slot: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !pwr_down) |=> (in_slot[0] == irq));
endmodule

bind gpio_slot_unit gpio_slot_chk #(.N(N), .SW(SW), .LSB(LSB)) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .pwr_down(pwr_down),
  .pin_out(pin_out), .pin_oe(pin_oe), .in_slot(in_slot), .irq(irq)
);

// File: tb/gpio_slot_unit_tb.sv
module gpio_slot_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_valid = 1'b0;
  logic [19:0] out_slot = '0;
  logic [19:0] in_slot;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_slot_unit u_dut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .out_slot(out_slot),
    .in_slot(in_slot), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] pins, input logic keep);
    @(negedge clk);
    out_slot    = {pins, 3'b000, keep};
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {16'h0, pin_out}, 32'h0);
    check("R1 in_slot", {12'h0, in_slot}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(1'b0, v); check("R1 dir reg", {16'h0, v}, 32'h0);
    rd(1'b1, v); check("R1 pwr reg", {16'h0, v}, 32'h0100);
  endtask

  task automatic t_power_up();
    logic [15:0] v;
    frame(16'hFFFF, 1'b1);
    check("R6 oe while down", {16'h0, pin_oe}, 32'h0);
    check("R6 slot while down", {12'h0, in_slot}, 32'h0);
    wr(1'b1, 16'hFEFF);
    rd(1'b1, v); check("R7 ready waits frame", {16'h0, v}, 32'h0);
    frame(16'h0000, 1'b1);
    rd(1'b1, v); check("R7 ready after frame", {16'h0, v}, 32'h0001);
    check("R3 dir zero floats", {16'h0, pin_oe}, 32'h0);
  endtask

  task automatic t_outputs();
    logic [15:0] v;
    wr(1'b0, 16'h00FF);
    rd(1'b0, v); check("R7 dir readback", {16'h0, v}, 32'h00FF);
    frame(16'hA5A5, 1'b1);
    check("R3 oe", {16'h0, pin_oe}, 32'h00FF);
    check("R3 out masked", {16'h0, pin_out}, 32'h00A5);
    check("R5 same-frame status", {16'h0, in_slot[19:4] & 16'h00FF}, 32'h0);
    check("R10 reserved bits", {29'h0, in_slot[3:1]}, 32'h0);
    @(negedge clk);
    out_slot = 20'hFFFF1;
    repeat (3) @(negedge clk);
    check("R2 no strobe no change", {16'h0, pin_out}, 32'h00A5);
    frame(16'h005A, 1'b1);
    check("R5 lagged status", {16'h0, in_slot[19:4] & 16'h00FF}, 32'h00A5);
    check("R2 new drive", {16'h0, pin_out}, 32'h005A);
  endtask

  task automatic t_inputs();
    pin_in = 16'h3C00;
    repeat (3) @(negedge clk);
    frame(16'hFF5A, 1'b1);
    check("R4 input status", {16'h0, in_slot[19:4] & 16'hFF00}, 32'h3C00);
    check("R3 ignored slot bits", {16'h0, pin_out}, 32'h005A);
    pin_in = 16'hC3FF;
    repeat (3) @(negedge clk);
    frame(16'h005A, 1'b1);
    check("R4 input status 2", {16'h0, in_slot[19:4] & 16'hFF00}, 32'hC300);
    check("R5 output status", {16'h0, in_slot[19:4] & 16'h00FF}, 32'h005A);
  endtask

  task automatic t_irq();
    frame(16'h005A, 1'b0);
    frame(16'h005A, 1'b0);
    check("R9 cleared", {31'h0, irq}, 32'h0);
    pin_in = 16'hC300;
    repeat (3) @(negedge clk);
    frame(16'h005A, 1'b1);
    check("R8 output pin change ignored", {31'h0, irq}, 32'h0);
    pin_in = 16'hC700;
    repeat (3) @(negedge clk);
    frame(16'h005A, 1'b1);
    check("R8 irq set", {31'h0, irq}, 32'h1);
    check("R8 slot flag", {31'h0, in_slot[0]}, 32'h1);
    frame(16'h005A, 1'b1);
    check("R9 sticky", {31'h0, irq}, 32'h1);
    frame(16'h005A, 1'b0);
    check("R9 clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_power_down();
    logic [15:0] v;
    wr(1'b1, 16'h0100);
    frame(16'hFFFF, 1'b1);
    check("R6 tri-state", {16'h0, pin_oe}, 32'h0);
    check("R6 zero slot", {12'h0, in_slot}, 32'h0);
    rd(1'b1, v); check("R7 down readback", {16'h0, v}, 32'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_power_up();
    t_outputs();
    t_inputs();
    t_irq();
    t_power_down();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule